// File: doc/BRIEF.md
# Scan-Based Fault Test Sequencer

This controller carries one fault-locating test through a small model of processor state. Starting from a base address, it walks an address register forward one word at a time. It fills a bank of target registers from the first words. It then fetches a control word and unpacks it into a control-store address, a 3-bit sequence counter and four status flags. The sequence counter's starting value sets how many microinstruction steps the test runs.

Each step hands the current control-store address to an external execution stub. The stub answers with the next address and an optional transfer strobe. The sequence counter increments after every step. When it reads seven, a fixed scan-out entry address is forced. The block then copies two test words to fixed locations and dumps its register and flag contents to memory. A one-cycle done pulse ends the test. Every memory access is timed, so a silent memory ends the test early with an error flag.

Memory addresses are byte addresses and the memory is a word-wide request/acknowledge port. One word occupies four address steps.

Top module: `fst_sequencer`

## Requirements
- R1: After reset the block is idle, with `memReq`, `uStep`, `done` and `err` all low. A `start` pulse while a test is in progress has no effect: it causes no second done pulse and no extra memory accesses.
- R2: After `start`, the first eleven reads are at `testBase`+4, +8 … +44, in that order. The address register only ever advances by one word before a read. The word read at `testBase`+4·(k+1) is loaded into target register k, for k = 0 to 10.
- R3: The twelfth read, at `testBase`+48, is the control word. Bits are numbered 0 at the MSB. Bits 0-2 (word[31:29]) seed the sequence counter, bits 19-30 (word[12:1]) seed the 12-bit control-store address, and bit 7 (word[24]) sets the I/O mode flag. The supervisory flag is forced to 1, and the supervisory-enable and progressive-scan flags are forced to 0, whatever bits 4-6 hold.
- R4: During clock advance, every cycle in which the sequence counter is not 7 is one step. In a step `uStep` is high and `uAddr` shows the current control-store address. The address then takes `uNext` and the counter increments. The test therefore makes exactly 7 − seed steps, and none when the seed is 7.
- R5: `uXfer` high during a step copies target register 0 into target register 1.
- R6: Once the counter reads 7, the control-store address is forced to 0x2C0 before scan-out begins.
- R7: Scan-out first reads `testBase`+52 and writes that word to 0x80. It then reads `testBase`+56 and writes that word to 0x84.
- R8: Scan-out then writes 14 words to DUMP_BASE+4·i (default 0x100), for i = 0 to 13. Words 0-10 are the target registers. Word 11 is status: seq in [2:0], supervisory-enable in [4], progressive-scan in [5], supervisory in [6], I/O mode in [7]. Word 12 is the control-store address and word 13 is the step count.
- R9: After the last dump write is acknowledged, `done` is high for exactly one cycle with `err` low, and the block returns to idle.
- R10: An access succeeds only if `memAck` arrives no later than the TIMEOUT-th cycle of its request, counting the first request cycle as 1. Otherwise the test stops: `err` rises together with a one-cycle `done`, and no further access is made. `err` holds until the next `start` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a test (sampled when idle) |
| testBase | input | 16 | Base byte address of the test words |
| memReq | output | 1 | Memory access request, held until acknowledged |
| memWe | output | 1 | High for a write access |
| memAddr | output | 16 | Byte address of the access |
| memWData | output | 32 | Write data |
| memRData | input | 32 | Read data, valid with `memAck` |
| memAck | input | 1 | Access acknowledge |
| uStep | output | 1 | Execution stub strobe, one per step |
| uAddr | output | 12 | Control-store address presented to the stub |
| uNext | input | 12 | Next control-store address from the stub |
| uXfer | input | 1 | Stub data-transfer strobe |
| done | output | 1 | One-cycle end-of-test pulse |
| err | output | 1 | Test ended on a memory timeout |

## Verification
The acknowledge of a pending access and the expiry of its wait window can land in the same cycle. The block must then accept the access rather than abort. The bench provokes this by holding the memory model's reply back by TIMEOUT−2 cycles, so the acknowledge lands exactly in the last permitted request cycle. It judges the run by a clean finish and a correct dump. It then delays one cycle more and expects an error finish with no write at all.

// File: rtl/fst_pkg.sv
package fst_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_SCAN_IN, S_FETCH_LCW, S_EXEC_LCW, S_CLOCK_ADV, S_SCAN_OUT, S_DONE
  } fstState_e;

  typedef enum logic [1:0] {
    A_NEXT, A_RESP, A_MASK, A_DUMP
  } addrSel_e;

  // Strobes from control to datapath, valid for one cycle each
  typedef struct packed {
    logic     iarInit;
    logic     iarAdv;
    logic     regWe;
    logic     tmpLoad;
    logic     lcwLoad;
    logic     stepExec;
    logic     forceEntry;
    logic     wrDump;
    addrSel_e addrSel;
  } fstStrobe_t;

endpackage

// File: rtl/fst_datapath.sv
module fst_datapath
  import fst_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 16,
  parameter int NREG = 11,
  parameter int ROAR_W = 12,
  parameter logic [AW-1:0] RESP_ADDR = 16'h0080,
  parameter logic [AW-1:0] MASK_ADDR = 16'h0084,
  parameter logic [AW-1:0] DUMP_BASE = 16'h0100,
  parameter logic [ROAR_W-1:0] ENTRY_ADDR = 12'h2C0
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  fstStrobe_t                stb,
  input  logic [$clog2(NREG)-1:0]   regIdx,
  input  logic [$clog2(NREG+3)-1:0] dumpIdx,
  input  logic [AW-1:0]             testBase,
  input  logic [DW-1:0]             memRData,
  output logic [AW-1:0]             memAddr,
  output logic [DW-1:0]             memWData,
  output logic                      seqEnd,
  output logic [ROAR_W-1:0]         uAddr,
  input  logic [ROAR_W-1:0]         uNext,
  input  logic                      uXfer
);
  localparam int IDX_W = $clog2(NREG);
  localparam int OUT_W = $clog2(NREG+3);
  localparam int SEQ_W = 3;
  localparam int STEP_W = SEQ_W + 1;
  localparam logic [SEQ_W-1:0] SEQ_END = '1;
  localparam logic [AW-1:0] STRIDE = AW'(DW/8);
  localparam logic [OUT_W-1:0] IDX_STATUS = OUT_W'(NREG);
  localparam logic [OUT_W-1:0] IDX_ROAR = OUT_W'(NREG+1);

  logic [DW-1:0]     regFile [NREG];
  logic [AW-1:0]     iar;
  logic [DW-1:0]     tmp;
  logic [SEQ_W-1:0]  seq;
  logic [ROAR_W-1:0] roar;
  logic [STEP_W-1:0] stepCnt;
  logic              supEn, progScan, supv, ioMode;
  logic [DW-1:0]     statusWord, dumpWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) regFile[i] <= '0;
    end else if (stb.regWe) begin
      regFile[regIdx] <= memRData;
    end else if (stb.stepExec && uXfer) begin
      regFile[1] <= regFile[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iar <= '0;
      tmp <= '0;
    end else begin
      if (stb.iarInit) iar <= testBase;
      else if (stb.iarAdv) iar <= iar + STRIDE;
      if (stb.tmpLoad) tmp <= memRData;
    end
  end

  // Control word: bit 0 is the MSB of the word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seq <= '0; roar <= '0; stepCnt <= '0;
      supEn <= 1'b0; progScan <= 1'b0; supv <= 1'b0; ioMode <= 1'b0;
    end else if (stb.lcwLoad) begin
      seq      <= tmp[DW-1 -: SEQ_W];
      roar     <= tmp[DW-20 -: ROAR_W];
      ioMode   <= tmp[DW-8];
      supv     <= 1'b1;
      supEn    <= 1'b0;
      progScan <= 1'b0;
      stepCnt  <= '0;
    end else if (stb.stepExec) begin
      roar    <= uNext;
      seq     <= seq + 1'b1;
      stepCnt <= stepCnt + 1'b1;
    end else if (stb.forceEntry) begin
      roar <= ENTRY_ADDR;
    end
  end

  assign seqEnd = (seq == SEQ_END);
  assign uAddr  = roar;

  always_comb begin
    statusWord = '0;
    statusWord[SEQ_W-1:0] = seq;
    statusWord[4] = supEn;
    statusWord[5] = progScan;
    statusWord[6] = supv;
    statusWord[7] = ioMode;
  end

  always_comb begin
    if (dumpIdx < IDX_STATUS)      dumpWord = regFile[IDX_W'(dumpIdx)];
    else if (dumpIdx == IDX_STATUS) dumpWord = statusWord;
    else if (dumpIdx == IDX_ROAR)   dumpWord = DW'(roar);
    else                            dumpWord = DW'(stepCnt);
  end

  always_comb begin
    unique case (stb.addrSel)
      A_NEXT:  memAddr = iar + STRIDE;
      A_RESP:  memAddr = RESP_ADDR;
      A_MASK:  memAddr = MASK_ADDR;
      default: memAddr = DUMP_BASE + AW'(dumpIdx) * STRIDE;
    endcase
  end

  assign memWData = stb.wrDump ? dumpWord : tmp;

  p_step_seq_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.stepExec |=> seq == $past(seq) + 1'b1);
  p_step_not_at_end_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.stepExec |-> !seqEnd);
  p_force_entry_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.forceEntry |=> (roar == ENTRY_ADDR) && seqEnd);
  p_lcw_flags_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.lcwLoad |=> supv && !supEn && !progScan);
  p_xfer_copy_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stepExec && uXfer) |=> regFile[1] == $past(regFile[0]));

endmodule

// File: rtl/fst_control.sv
module fst_control
  import fst_pkg::*;
#(
  parameter int NREG = 11,
  parameter int TIMEOUT = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic                      memAck,
  input  logic                      seqEnd,
  output fstStrobe_t                stb,
  output logic [$clog2(NREG)-1:0]   regIdx,
  output logic [$clog2(NREG+3)-1:0] dumpIdx,
  output logic                      memReq,
  output logic                      memWe,
  output logic                      done,
  output logic                      err
);
  localparam int IDX_W = $clog2(NREG);
  localparam int OUT_W = $clog2(NREG+3);
  localparam int WAIT_W = $clog2(TIMEOUT+1);
  localparam logic [IDX_W-1:0] IN_LAST = IDX_W'(NREG-1);
  localparam logic [OUT_W-1:0] OUT_LAST = OUT_W'(NREG+2);
  localparam logic [WAIT_W-1:0] TO_LAST = WAIT_W'(TIMEOUT-1);
  localparam logic [WAIT_W-1:0] TO_LIM = WAIT_W'(TIMEOUT);
  localparam logic [2:0] HDR_DUMP = 3'd4;

  fstState_e          state;
  logic [IDX_W-1:0]   inCnt;
  logic [OUT_W-1:0]   outCnt;
  logic [2:0]         hdr;
  logic [WAIT_W-1:0]  waitCnt;
  logic               accOk, accExpire;

  assign accOk     = memReq && memAck;
  assign accExpire = memReq && !memAck && (waitCnt == TO_LAST);
  assign regIdx    = inCnt;
  assign dumpIdx   = outCnt;

  always_comb begin
    stb = '0;
    stb.addrSel = A_NEXT;
    memReq = 1'b0;
    memWe  = 1'b0;
    done   = 1'b0;
    unique case (state)
      S_IDLE:      stb.iarInit = start;
      S_SCAN_IN: begin
        memReq = 1'b1;
        stb.iarAdv = memAck;
        stb.regWe  = memAck;
      end
      S_FETCH_LCW: begin
        memReq = 1'b1;
        stb.iarAdv  = memAck;
        stb.tmpLoad = memAck;
      end
      S_EXEC_LCW:  stb.lcwLoad = 1'b1;
      S_CLOCK_ADV: begin
        stb.forceEntry = seqEnd;
        stb.stepExec   = !seqEnd;
      end
      S_SCAN_OUT: begin
        memReq = 1'b1;
        unique case (hdr)
          3'd0, 3'd2: begin
            stb.iarAdv  = memAck;
            stb.tmpLoad = memAck;
          end
          3'd1: begin memWe = 1'b1; stb.addrSel = A_RESP; end
          3'd3: begin memWe = 1'b1; stb.addrSel = A_MASK; end
          default: begin
            memWe = 1'b1;
            stb.addrSel = A_DUMP;
            stb.wrDump = 1'b1;
          end
        endcase
      end
      default:     done = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; inCnt <= '0; outCnt <= '0; hdr <= '0;
      waitCnt <= '0; err <= 1'b0;
    end else begin
      if (memReq) waitCnt <= memAck ? '0 : waitCnt + 1'b1;
      if (accExpire) begin
        state   <= S_DONE;
        err     <= 1'b1;
        waitCnt <= '0;
      end else begin
        unique case (state)
          S_IDLE: if (start) begin
            state <= S_SCAN_IN; err <= 1'b0; inCnt <= '0; waitCnt <= '0;
          end
          S_SCAN_IN: if (accOk) begin
            if (inCnt == IN_LAST) state <= S_FETCH_LCW;
            else inCnt <= inCnt + 1'b1;
          end
          S_FETCH_LCW: if (accOk) state <= S_EXEC_LCW;
          S_EXEC_LCW: begin
            state <= S_CLOCK_ADV; hdr <= '0; outCnt <= '0;
          end
          S_CLOCK_ADV: if (seqEnd) state <= S_SCAN_OUT;
          S_SCAN_OUT: if (accOk) begin
            if (hdr != HDR_DUMP) hdr <= hdr + 1'b1;
            else if (outCnt == OUT_LAST) state <= S_DONE;
            else outCnt <= outCnt + 1'b1;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_busy_no_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE && state != S_DONE) |=> state != S_IDLE);
  p_wait_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> waitCnt < TO_LIM);
  p_expire_err_r10: assert property (@(posedge clk) disable iff (!rstN)
    accExpire |=> err && done && !memReq);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |-> !memReq && !stb.stepExec);

endmodule

// File: rtl/fst_sequencer.sv
module fst_sequencer
  import fst_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 16,
  parameter int NREG = 11,
  parameter int ROAR_W = 12,
  parameter int TIMEOUT = 8,
  parameter logic [AW-1:0] DUMP_BASE = 16'h0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [AW-1:0]     testBase,
  output logic              memReq,
  output logic              memWe,
  output logic [AW-1:0]     memAddr,
  output logic [DW-1:0]     memWData,
  input  logic [DW-1:0]     memRData,
  input  logic              memAck,
  output logic              uStep,
  output logic [ROAR_W-1:0] uAddr,
  input  logic [ROAR_W-1:0] uNext,
  input  logic              uXfer,
  output logic              done,
  output logic              err
);
  fstStrobe_t                stb;
  logic [$clog2(NREG)-1:0]   regIdx;
  logic [$clog2(NREG+3)-1:0] dumpIdx;
  logic                      seqEnd;

  fst_control #(.NREG(NREG), .TIMEOUT(TIMEOUT)) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .memAck(memAck), .seqEnd(seqEnd),
    .stb(stb), .regIdx(regIdx), .dumpIdx(dumpIdx),
    .memReq(memReq), .memWe(memWe), .done(done), .err(err)
  );

  fst_datapath #(.DW(DW), .AW(AW), .NREG(NREG), .ROAR_W(ROAR_W),
                 .DUMP_BASE(DUMP_BASE)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regIdx(regIdx), .dumpIdx(dumpIdx),
    .testBase(testBase), .memRData(memRData), .memAddr(memAddr),
    .memWData(memWData), .seqEnd(seqEnd), .uAddr(uAddr), .uNext(uNext),
    .uXfer(uXfer)
  );

  assign uStep = stb.stepExec;

endmodule

// File: tb/fst_sequencer_tb.sv
module fst_sequencer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] testBase = '0;
  logic        memReq, memWe, memAck, uStep, uXfer, done, err;
  logic [15:0] memAddr;
  logic [31:0] memWData, memRData;
  logic [11:0] uAddr, uNext;

  int vectors = 0, misses = 0;
  int ackDelay = 0;
  logic [15:0] curBase = '0;
  logic [31:0] curLcw = '0;
  logic        xferEn = 1'b0;

  // memory model state, driven only by the model process
  logic [31:0] wrMem [256];
  logic [15:0] rdLog [256];
  logic [15:0] wrLog [256];
  int rdTot = 0, wrTot = 0, cnt = 0;
  logic [11:0] stepLog [256];
  int stepTot = 0, doneTot = 0;

  always #5 clk = ~clk;

  fst_sequencer u_dut (
    .clk(clk), .rstN(rstN), .start(start), .testBase(testBase),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWData(memWData),
    .memRData(memRData), .memAck(memAck), .uStep(uStep), .uAddr(uAddr),
    .uNext(uNext), .uXfer(uXfer), .done(done), .err(err)
  );

  assign uNext = uAddr + 12'h011;
  assign uXfer = xferEn;

  function automatic logic [31:0] wordAt(logic [15:0] a);
    if (a == curBase + 16'd48) return curLcw;
    return {16'hB00C, a} ^ {a, 16'h0000};
  endfunction

  function automatic logic [31:0] mkLcw(logic [2:0] sq, logic [11:0] ra, logic [3:0] b4to7);
    logic [31:0] w;
    w = '0;
    w[31:29] = sq;
    w[27:24] = b4to7;
    w[12:1]  = ra;
    return w;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      memAck <= 1'b0; cnt <= 0; memRData <= '0;
    end else if (memAck) begin
      memAck <= 1'b0; cnt <= 0;
    end else if (memReq) begin
      if (cnt == ackDelay) begin
        memAck <= 1'b1;
        if (memWe) begin
          wrMem[memAddr[9:2]] <= memWData;
          wrLog[wrTot[7:0]] <= memAddr;
          wrTot <= wrTot + 1;
        end else begin
          memRData <= wordAt(memAddr);
          rdLog[rdTot[7:0]] <= memAddr;
          rdTot <= rdTot + 1;
        end
      end else cnt <= cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (uStep) begin
      stepLog[stepTot[7:0]] <= uAddr;
      stepTot <= stepTot + 1;
    end
    if (done) doneTot <= doneTot + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  int rd0, wr0, st0, dn0;
  bit timedOut;

  task automatic runTest(input logic [15:0] base, input logic [31:0] lcw,
                         input bit xf, input int dly, input bit pokeStart);
    int n;
    curBase = base; curLcw = lcw; xferEn = xf; ackDelay = dly;
    rd0 = rdTot; wr0 = wrTot; st0 = stepTot; dn0 = doneTot;
    @(posedge clk); #1 testBase = base; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    n = 0;
    timedOut = 0;
    @(negedge clk);
    while (!done && n < 5000) begin
      if (pokeStart && n == 10) begin
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk);
        n += 2;
      end else begin
        @(negedge clk); n++;
      end
    end
    if (!done) begin
      timedOut = 1;
      chk(1'b0, "watchdog R9", 32'(n), 32'd5000);
    end
  endtask

  task automatic checkRun(input string nm, input logic [15:0] base, input logic [2:0] sq,
                          input logic [11:0] ra, input bit io, input bit xf);
    int steps;
    bit ok;
    logic [31:0] expW, st;
    chk(err == 1'b0, {nm, " R9 err low at done"}, 32'(err), 32'd0);
    @(negedge clk);
    chk(done == 1'b0, {nm, " R9 done is one cycle"}, 32'(done), 32'd0);
    chk(doneTot - dn0 == 1, {nm, " R1 single done"}, 32'(doneTot - dn0), 32'd1);
    // R2 R3 R7 read order
    ok = (rdTot - rd0 == 14);
    for (int k = 0; k < 14; k++)
      if (rdLog[8'(rd0 + k)] != base + 16'(4 * (k + 1))) ok = 0;
    chk(ok, {nm, " R2 R7 read addresses"}, 32'(rdTot - rd0), 32'd14);
    // R7 R8 write order
    ok = (wrTot - wr0 == 16);
    if (wrLog[8'(wr0)] != 16'h0080 || wrLog[8'(wr0 + 1)] != 16'h0084) ok = 0;
    for (int k = 0; k < 14; k++)
      if (wrLog[8'(wr0 + 2 + k)] != 16'h0100 + 16'(4 * k)) ok = 0;
    chk(ok, {nm, " R8 write addresses"}, 32'(wrTot - wr0), 32'd16);
    chk(wrMem[32] == wordAt(base + 16'd52), {nm, " R7 word13 at 0x80"}, wrMem[32], wordAt(base + 16'd52));
    chk(wrMem[33] == wordAt(base + 16'd56), {nm, " R7 word14 at 0x84"}, wrMem[33], wordAt(base + 16'd56));
    for (int k = 0; k < 11; k++) begin
      expW = (k == 1 && xf && sq != 3'd7) ? wordAt(base + 16'd4) : wordAt(base + 16'(4 * (k + 1)));
      chk(wrMem[64 + k] == expW, {nm, (k == 1 ? " R5" : " R2"), " target register dump"}, wrMem[64 + k], expW);
    end
    st = 32'h47 | (32'(io) << 7);
    chk(wrMem[75] == st, {nm, " R3 status word"}, wrMem[75], st);
    chk(wrMem[76] == 32'h2C0, {nm, " R6 entry address"}, wrMem[76], 32'h2C0);
    steps = 7 - int'(sq);
    chk(wrMem[77] == 32'(steps), {nm, " R4 step count dumped"}, wrMem[77], 32'(steps));
    chk(stepTot - st0 == steps, {nm, " R4 uStep pulses"}, 32'(stepTot - st0), 32'(steps));
    for (int k = 0; k < steps; k++) begin
      expW = 32'(ra + 12'(k * 17));
      chk(32'(stepLog[8'(st0 + k)]) == expW, {nm, " R4 uAddr per step"}, 32'(stepLog[8'(st0 + k)]), expW);
    end
  endtask

  task automatic t_reset;
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk({memReq, uStep, done, err} == 4'b0, "R1 reset outputs idle", 32'({memReq, uStep, done, err}), 32'd0);
  endtask

  task automatic t_basic;
    runTest(16'h0000, mkLcw(3'd5, 12'h123, 4'b0111), 1'b0, 0, 1'b0);
    if (!timedOut) checkRun("basic", 16'h0000, 3'd5, 12'h123, 1'b1, 1'b0);
  endtask

  task automatic t_no_steps;
    runTest(16'h0040, mkLcw(3'd7, 12'hABC, 4'b1110), 1'b1, 0, 1'b0);
    if (!timedOut) checkRun("seed7", 16'h0040, 3'd7, 12'hABC, 1'b0, 1'b1);
  endtask

  task automatic t_full_xfer;
    runTest(16'h0000, mkLcw(3'd0, 12'h010, 4'b0001), 1'b1, 1, 1'b0);
    if (!timedOut) checkRun("seed0", 16'h0000, 3'd0, 12'h010, 1'b1, 1'b1);
  endtask

  task automatic t_late_ack;
    runTest(16'h0040, mkLcw(3'd4, 12'h200, 4'b0000), 1'b0, 6, 1'b0);
    if (!timedOut) checkRun("lastcycle R10", 16'h0040, 3'd4, 12'h200, 1'b0, 1'b0);
  endtask

  task automatic t_timeout;
    runTest(16'h0000, mkLcw(3'd5, 12'h123, 4'b0001), 1'b0, 7, 1'b0);
    if (!timedOut) begin
      chk(err == 1'b1, "R10 err with done", 32'(err), 32'd1);
      repeat (20) @(negedge clk);
      chk(wrTot - wr0 == 0, "R10 no write after expiry", 32'(wrTot - wr0), 32'd0);
      chk(rdTot - rd0 <= 1, "R10 no further read", 32'(rdTot - rd0), 32'd1);
      chk({memReq, err} == 2'b01, "R10 idle with err held", 32'({memReq, err}), 32'd1);
      chk(doneTot - dn0 == 1, "R10 single done", 32'(doneTot - dn0), 32'd1);
    end
    runTest(16'h0000, mkLcw(3'd6, 12'h055, 4'b0000), 1'b0, 0, 1'b0);
    if (!timedOut) checkRun("recover R10", 16'h0000, 3'd6, 12'h055, 1'b0, 1'b0);
  endtask

  task automatic t_busy_start;
    runTest(16'h0040, mkLcw(3'd3, 12'h0F0, 4'b0001), 1'b0, 2, 1'b1);
    if (!timedOut) begin
      checkRun("busystart R1", 16'h0040, 3'd3, 12'h0F0, 1'b1, 1'b0);
      repeat (30) @(negedge clk);
      chk(doneTot - dn0 == 1 && !memReq, "R1 start while busy ignored", 32'(doneTot - dn0), 32'd1);
    end
  endtask

  initial begin
    t_reset();
    t_basic();
    t_no_steps();
    t_full_xfer();
    t_late_ack();
    t_timeout();
    t_busy_start();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule